// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home-side coherence controller for a group of memory lines. Each line owns a directory entry that holds a presence vector with one bit per processor and a single dirty flag. The line contents sit in a small internal array next to the directory. Requests arrive one per cycle as messages that carry a kind, a requester number, a line index and, for write-backs, a data word. Each read or write miss gets a single response message exactly one cycle later.

A read of a clean line is served from the array and adds the requester to the sharers. A read of a dirty line gets no data. The controller names the owner so the requester can fetch the line from that owner, and it marks the line busy until the owner writes it back. A write miss to a clean line returns the data together with the full sharer vector. The requester then invalidates those sharers itself and may write only after every sharer has acknowledged. After a write miss the requester is the sole, dirty holder. A write miss to a dirty line is handled like a dirty read, but the final write-back hands exclusive ownership to the writer.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, every entry is clean, empty and not busy, `rsp_valid` is low, and line i holds the word (i * 0x9E3779B1) ^ 0x5A5A0000, truncated to 32 bits.
- R2: A read miss (kind 0) to a clean, non-busy line answers kind DATA (0) with the stored word and adds the requester to the presence vector.
- R3: A read miss to a dirty, non-busy line answers kind OWNER (1), with the owner's binary number in `rsp_owner` and zero data. The entry does not change, except that the line becomes busy.
- R4: While a line is busy, any read or write miss to it answers kind NACK (2'd3) and leaves the entry and the line data unchanged.
- R5: A write-back (kind 2) from the owner of a busy line writes its data into the array, clears busy and produces no response. When the pending request was a read, the line becomes clean and shared by the owner and the reader.
- R6: A write miss (kind 1) to a clean, non-busy line answers kind SHARERS (2) with the stored word and the presence vector minus the requester (bit i = processor i). The entry then holds only the requester, with dirty set.
- R7: A write miss to a dirty, non-busy line answers kind OWNER and makes the line busy. The owner's later write-back stores the data and leaves the writer as the sole dirty holder.
- R8: A write-back to a line that is not busy, or one from a processor that is not the owner, has no effect, and so does request kind 3: there is no response and the line data and entry stay the same.
- R9: Every response appears exactly one cycle after its request, with `rsp_dst` equal to the requester. Fields the kind does not use read zero, and `rsp_valid` stays low when no request arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 owner write-back, 3 reserved |
| req_src | input | SRC_W | Requesting processor number |
| req_line | input | LINE_W | Line index |
| req_data | input | DATA_W | Write-back data |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 0 data, 1 owner, 2 sharers+data, 3 nack |
| rsp_dst | output | SRC_W | Destination processor |
| rsp_owner | output | SRC_W | Owner number for kind 1 |
| rsp_sharers | output | NPROC | Sharer vector for kind 2 |
| rsp_data | output | DATA_W | Line data for kinds 0 and 2 |

## Verification
The assertions assume that `req_src` and `req_line` stay in range and that a write-back only arrives as a new request message, never repeated from one cycle to the next. Under that assumption, a dirty entry always has exactly one presence bit, and busy always implies dirty. The stimulus draws requester numbers only below the processor count and line indices from the legal range. It aims write-backs mostly at the owner of busy lines, while still sending strays, so that each assumed path is exercised without breaking the input contract.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;
  typedef enum logic [1:0] {
    REQ_RD  = 2'd0,
    REQ_WR  = 2'd1,
    REQ_WB  = 2'd2,
    REQ_RSV = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    RSP_DATA    = 2'd0,
    RSP_OWNER   = 2'd1,
    RSP_SHARERS = 2'd2,
    RSP_NACK    = 2'd3
  } rsp_kind_e;

  // power-up contents of a line, 32-bit arithmetic
  function automatic logic [31:0] seed_word(input int unsigned idx);
    logic [31:0] p;
    p = 32'(idx) * 32'h9E37_79B1;
    return p ^ 32'h5A5A_0000;
  endfunction
endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store #(
  parameter int NPROC  = 8,
  parameter int NLINES = 16,
  parameter int SRC_W  = 3,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line,
  output logic [NPROC-1:0]  rd_pres,
  output logic              rd_dirty,
  output logic              rd_busy,
  output logic [SRC_W-1:0]  rd_pend_src,
  output logic              rd_pend_wr,
  input  logic              we,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [NPROC-1:0]  wr_pres,
  input  logic              wr_dirty,
  input  logic              wr_busy,
  input  logic [SRC_W-1:0]  wr_pend_src,
  input  logic              wr_pend_wr
);
  logic [NPROC-1:0] pres_q     [NLINES];
  logic             dirty_q    [NLINES];
  logic             busy_q     [NLINES];
  logic [SRC_W-1:0] pend_src_q [NLINES];
  logic             pend_wr_q  [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic hit;
    assign hit = we && (wr_line == LINE_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pres_q[g]     <= '0;
        dirty_q[g]    <= 1'b0;
        busy_q[g]     <= 1'b0;
        pend_src_q[g] <= '0;
        pend_wr_q[g]  <= 1'b0;
      end else if (hit) begin
        pres_q[g]     <= wr_pres;
        dirty_q[g]    <= wr_dirty;
        busy_q[g]     <= wr_busy;
        pend_src_q[g] <= wr_pend_src;
        pend_wr_q[g]  <= wr_pend_wr;
      end
    end

    // a dirty line has exactly one holder (R3, R6)
    assert_dirty_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q[g] |-> ($countones(pres_q[g]) == 1));

    // busy only arises on dirty lines (R4)
    assert_busy_implies_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q[g] |-> dirty_q[g]);
  end

  assign rd_pres     = pres_q[rd_line];
  assign rd_dirty    = dirty_q[rd_line];
  assign rd_busy     = busy_q[rd_line];
  assign rd_pend_src = pend_src_q[rd_line];
  assign rd_pend_wr  = pend_wr_q[rd_line];
endmodule

// File: rtl/dir_line_mem.sv
module dir_line_mem #(
  parameter int NLINES = 16,
  parameter int DATA_W = 32,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [DATA_W-1:0] wr_data
);
  import dir_home_pkg::*;

  logic [DATA_W-1:0] mem_q [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_q[g] <= DATA_W'(seed_word(g));
      else if (we && (wr_line == LINE_W'(g)))
        mem_q[g] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_line];
endmodule

// File: rtl/dir_policy.sv
module dir_policy #(
  parameter int NPROC  = 8,
  parameter int SRC_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [DATA_W-1:0] req_data,
  input  logic [NPROC-1:0]  cur_pres,
  input  logic              cur_dirty,
  input  logic              cur_busy,
  input  logic [SRC_W-1:0]  cur_pend_src,
  input  logic              cur_pend_wr,
  input  logic [DATA_W-1:0] cur_data,
  output logic              ent_we,
  output logic [NPROC-1:0]  nxt_pres,
  output logic              nxt_dirty,
  output logic              nxt_busy,
  output logic [SRC_W-1:0]  nxt_pend_src,
  output logic              nxt_pend_wr,
  output logic              mem_we,
  output logic              rsp_fire,
  output logic [1:0]        rsp_kind_d,
  output logic [SRC_W-1:0]  rsp_owner_d,
  output logic [NPROC-1:0]  rsp_sharers_d,
  output logic [DATA_W-1:0] rsp_data_d,
  output logic              ev_nack,
  output logic              ev_wb_accept
);
  import dir_home_pkg::*;

  function automatic logic [NPROC-1:0] proc_bit(input logic [SRC_W-1:0] id);
    return NPROC'(1) << id;
  endfunction

  function automatic logic [SRC_W-1:0] owner_num(input logic [NPROC-1:0] v);
    logic [SRC_W-1:0] r;
    r = '0;
    for (int i = 0; i < NPROC; i++)
      if (v[i]) r = SRC_W'(i);
    return r;
  endfunction

  req_kind_e kind;
  logic      is_miss;
  assign kind    = req_kind_e'(req_kind);
  assign is_miss = (kind == REQ_RD) || (kind == REQ_WR);

  always_comb begin
    ent_we        = 1'b0;
    nxt_pres      = cur_pres;
    nxt_dirty     = cur_dirty;
    nxt_busy      = cur_busy;
    nxt_pend_src  = cur_pend_src;
    nxt_pend_wr   = cur_pend_wr;
    mem_we        = 1'b0;
    rsp_fire      = 1'b0;
    rsp_kind_d    = RSP_DATA;
    rsp_owner_d   = '0;
    rsp_sharers_d = '0;
    rsp_data_d    = '0;
    ev_nack       = 1'b0;
    ev_wb_accept  = 1'b0;
    if (req_valid) begin
      if (is_miss && cur_busy) begin
        rsp_fire   = 1'b1;
        rsp_kind_d = RSP_NACK;
        ev_nack    = 1'b1;
      end else if (is_miss && cur_dirty) begin
        rsp_fire     = 1'b1;
        rsp_kind_d   = RSP_OWNER;
        rsp_owner_d  = owner_num(cur_pres);
        ent_we       = 1'b1;
        nxt_busy     = 1'b1;
        nxt_pend_src = req_src;
        nxt_pend_wr  = (kind == REQ_WR);
      end else if (kind == REQ_RD) begin
        rsp_fire   = 1'b1;
        rsp_kind_d = RSP_DATA;
        rsp_data_d = cur_data;
        ent_we     = 1'b1;
        nxt_pres   = cur_pres | proc_bit(req_src);
      end else if (kind == REQ_WR) begin
        rsp_fire      = 1'b1;
        rsp_kind_d    = RSP_SHARERS;
        rsp_data_d    = cur_data;
        rsp_sharers_d = cur_pres & ~proc_bit(req_src);
        ent_we        = 1'b1;
        nxt_pres      = proc_bit(req_src);
        nxt_dirty     = 1'b1;
      end else if (kind == REQ_WB && cur_busy && cur_pres[req_src]) begin
        ev_wb_accept = 1'b1;
        mem_we       = 1'b1;
        ent_we       = 1'b1;
        nxt_busy     = 1'b0;
        if (cur_pend_wr) begin
          nxt_pres  = proc_bit(cur_pend_src);
          nxt_dirty = 1'b1;
        end else begin
          nxt_pres  = cur_pres | proc_bit(cur_pend_src);
          nxt_dirty = 1'b0;
        end
      end
    end
  end

  // write-back data is the only source of array writes (R5)
  always_comb begin
    if (mem_we) assert_mem_write_from_wb_R5: assert (kind == REQ_WB);
  end

  // unused data input keeps its name for the array write path
  logic unused_ok;
  assign unused_ok = ^req_data;
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NPROC  = 8,
  parameter int NLINES = 16,
  parameter int DATA_W = 32,
  localparam int SRC_W  = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [LINE_W-1:0] req_line,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [SRC_W-1:0]  rsp_dst,
  output logic [SRC_W-1:0]  rsp_owner,
  output logic [NPROC-1:0]  rsp_sharers,
  output logic [DATA_W-1:0] rsp_data
);
  import dir_home_pkg::*;

  logic [NPROC-1:0]  cur_pres, nxt_pres, rsp_sharers_d;
  logic              cur_dirty, cur_busy, cur_pend_wr;
  logic [SRC_W-1:0]  cur_pend_src, nxt_pend_src, rsp_owner_d;
  logic              nxt_dirty, nxt_busy, nxt_pend_wr;
  logic [DATA_W-1:0] cur_data, rsp_data_d;
  logic              ent_we, mem_we, rsp_fire, ev_nack, ev_wb_accept;
  logic [1:0]        rsp_kind_d;

  dir_entry_store #(.NPROC(NPROC), .NLINES(NLINES), .SRC_W(SRC_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_line(req_line),
    .rd_pres(cur_pres), .rd_dirty(cur_dirty), .rd_busy(cur_busy),
    .rd_pend_src(cur_pend_src), .rd_pend_wr(cur_pend_wr),
    .we(ent_we), .wr_line(req_line), .wr_pres(nxt_pres), .wr_dirty(nxt_dirty),
    .wr_busy(nxt_busy), .wr_pend_src(nxt_pend_src), .wr_pend_wr(nxt_pend_wr)
  );

  dir_line_mem #(.NLINES(NLINES), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_line(req_line), .rd_data(cur_data),
    .we(mem_we), .wr_line(req_line), .wr_data(req_data)
  );

  dir_policy #(.NPROC(NPROC), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_policy (
    .req_valid(req_valid), .req_kind(req_kind), .req_src(req_src), .req_data(req_data),
    .cur_pres(cur_pres), .cur_dirty(cur_dirty), .cur_busy(cur_busy),
    .cur_pend_src(cur_pend_src), .cur_pend_wr(cur_pend_wr), .cur_data(cur_data),
    .ent_we(ent_we), .nxt_pres(nxt_pres), .nxt_dirty(nxt_dirty), .nxt_busy(nxt_busy),
    .nxt_pend_src(nxt_pend_src), .nxt_pend_wr(nxt_pend_wr), .mem_we(mem_we),
    .rsp_fire(rsp_fire), .rsp_kind_d(rsp_kind_d), .rsp_owner_d(rsp_owner_d),
    .rsp_sharers_d(rsp_sharers_d), .rsp_data_d(rsp_data_d),
    .ev_nack(ev_nack), .ev_wb_accept(ev_wb_accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_kind    <= '0;
      rsp_dst     <= '0;
      rsp_owner   <= '0;
      rsp_sharers <= '0;
      rsp_data    <= '0;
    end else begin
      rsp_valid   <= rsp_fire;
      rsp_kind    <= rsp_fire ? rsp_kind_d    : '0;
      rsp_dst     <= rsp_fire ? req_src       : '0;
      rsp_owner   <= rsp_fire ? rsp_owner_d   : '0;
      rsp_sharers <= rsp_fire ? rsp_sharers_d : '0;
      rsp_data    <= rsp_fire ? rsp_data_d    : '0;
    end
  end

  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid) && rsp_dst == $past(req_src)));

  assert_busy_nacks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> (rsp_valid && rsp_kind == RSP_NACK));

  assert_clean_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RSP_DATA) |-> !$past(cur_dirty));

  assert_wb_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_accept |=> !rsp_valid);

  assert_owner_has_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RSP_OWNER) |-> (rsp_data == '0 && rsp_sharers == '0));
endmodule

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
  localparam int NP = 8;
  localparam int NL = 16;
  localparam int SW = 3;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [SW-1:0] req_src = '0;
  logic [LW-1:0] req_line = '0;
  logic [31:0] req_data = '0;
  logic rsp_valid;
  logic [1:0] rsp_kind;
  logic [SW-1:0] rsp_dst, rsp_owner;
  logic [NP-1:0] rsp_sharers;
  logic [31:0] rsp_data;

  dir_home_ctrl #(.NPROC(NP), .NLINES(NL), .DATA_W(32)) i_dir_home_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_src(req_src), .req_line(req_line), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
    .rsp_owner(rsp_owner), .rsp_sharers(rsp_sharers), .rsp_data(rsp_data)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // model of the home state
  logic [NP-1:0] m_pres [NL];
  bit            m_dirty[NL];
  bit            m_busy [NL];
  int            m_psrc [NL];
  bit            m_pwr  [NL];
  logic [31:0]   m_mem  [NL];

  function automatic logic [31:0] power_up(int i);
    longint unsigned v;
    v = (longint'(i) * 64'd2654435761) & 64'hFFFF_FFFF;
    return 32'(v) ^ 32'h5A5A_0000;
  endfunction

  function automatic int holder(logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  // expected response: {valid, kind, dst, owner, sharers, data}
  typedef struct packed {
    logic v; logic [1:0] k; logic [SW-1:0] d; logic [SW-1:0] o;
    logic [NP-1:0] s; logic [31:0] x;
  } exp_t;

  task automatic check(exp_t e, string tag);
    exp_t a;
    a = '{rsp_valid, rsp_kind, rsp_dst, rsp_owner, rsp_sharers, rsp_data};
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: actual v=%0b k=%0d d=%0d o=%0d s=%b x=%h expected v=%0b k=%0d d=%0d o=%0d s=%b x=%h",
        tag, a.v, a.k, a.d, a.o, a.s, a.x, e.v, e.k, e.d, e.o, e.s, e.x);
    end
  endtask

  task automatic send(int kind, int src, int line, logic [31:0] data, string force_tag);
    exp_t e;
    string tag;
    bit miss;
    e = '0;
    miss = (kind == 0 || kind == 1);
    if (miss && m_busy[line]) begin
      e = '{1'b1, 2'd3, SW'(src), '0, '0, '0}; tag = "R4";
    end else if (miss && m_dirty[line]) begin
      e = '{1'b1, 2'd1, SW'(src), SW'(holder(m_pres[line])), '0, '0};
      tag = (kind == 0) ? "R3" : "R7";
      m_busy[line] = 1; m_psrc[line] = src; m_pwr[line] = (kind == 1);
    end else if (kind == 0) begin
      e = '{1'b1, 2'd0, SW'(src), '0, '0, m_mem[line]}; tag = "R2";
      m_pres[line][src] = 1'b1;
    end else if (kind == 1) begin
      logic [NP-1:0] sh;
      sh = m_pres[line]; sh[src] = 1'b0;
      e = '{1'b1, 2'd2, SW'(src), '0, sh, m_mem[line]}; tag = "R6";
      m_pres[line] = '0; m_pres[line][src] = 1'b1; m_dirty[line] = 1;
    end else if (kind == 2 && m_busy[line] && m_pres[line][src]) begin
      tag = m_pwr[line] ? "R7" : "R5";
      m_mem[line] = data; m_busy[line] = 0;
      if (m_pwr[line]) begin
        m_pres[line] = '0; m_pres[line][m_psrc[line]] = 1'b1;
      end else begin
        m_pres[line][m_psrc[line]] = 1'b1; m_dirty[line] = 0;
      end
    end else begin
      tag = "R8";
    end
    if (force_tag != "") tag = force_tag;
    req_valid = 1'b1; req_kind = 2'(kind); req_src = SW'(src);
    req_line = LW'(line); req_data = data;
    @(negedge clk);
    check(e, tag);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    req_kind = 2'($urandom_range(0, 3));
    @(negedge clk);
    check('0, "R9");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NL; i++) begin
      m_pres[i] = '0; m_dirty[i] = 0; m_busy[i] = 0;
      m_psrc[i] = 0; m_pwr[i] = 0; m_mem[i] = power_up(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check('0, "R1");
    // R1: every line powers up clean with its seed word
    for (int i = 0; i < NL; i++) send(0, i % NP, i, '0, "R1");
    // R2: more sharers on line 3
    send(0, 1, 3, '0, ""); send(0, 2, 3, '0, ""); send(0, 5, 3, '0, "");
    // R6: write miss by a current sharer
    send(1, 2, 3, '0, "");
    // R3 then R4
    send(0, 4, 3, '0, "");
    send(0, 6, 3, '0, ""); send(1, 7, 3, '0, "");
    // R8: strays and reserved kind, then proof of no effect
    send(2, 5, 3, 32'hDEAD_0001, "");
    send(2, 0, 4, 32'hDEAD_0002, "");
    send(3, 0, 4, 32'hDEAD_0003, "");
    send(0, 1, 4, '0, "R8");
    // R5: owner write-back closes the dirty read
    send(2, 2, 3, 32'hCAFE_1234, "");
    send(0, 0, 3, '0, "R5");
    // R7: write miss to a dirty line
    send(1, 1, 3, '0, "");
    send(1, 6, 3, '0, "");
    send(2, 1, 3, 32'h7777_AAAA, "");
    send(0, 0, 3, '0, "R7");
    send(2, 6, 3, 32'h1357_9BDF, "");
    send(0, 6, 3, '0, "R5");
    idle(); idle();
    // random traffic on a few lines to force collisions
    for (int n = 0; n < 4000; n++) begin
      int line, src, kind;
      line = $urandom_range(0, 3);
      src = $urandom_range(0, NP - 1);
      kind = $urandom_range(0, 3);
      if (m_busy[line] && ($urandom_range(0, 1) == 1)) begin
        kind = 2; src = holder(m_pres[line]);
      end
      if ($urandom_range(0, 15) == 0) idle();
      else send(kind, src, line, $urandom(), "");
    end
    idle();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R9: watchdog expired, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule